// File: doc/BRIEF.md
# Fixed-Map PCM Frame Commutator

This block turns a set of host-written parameter registers into a continuous serial telemetry stream with a fixed layout. Each minor frame opens with a 32-bit sync pattern spread over two 16-bit word slots. The next two slots carry a minor frame counter and a timestamp. All remaining slots are data slots. Each data slot gets its content from a map table entry, which names either a parameter register or fill. The map covers the data slots of a whole major frame in order. A major frame is a configured number of consecutive minor frames.

A parameter can be placed in several evenly spaced data slots of a minor frame, for example at the start, the quarter, the half and the three-quarter points. Sample time is then implied by slot position, so one timestamp per minor frame is enough. The stream advances one bit on each bit-clock enable, most significant bit first.

The map, the minor frame length, the minor frame count and the sync pattern are held in working copies. These copies are refreshed only when a major frame ends, so a reprogram never produces a partial frame. Before the first bit-clock enable after reset, the working copies follow the configuration inputs directly.

Top module: `pcm_commutator`

## Requirements
- R1: After reset, serOut and frameStart are 0, and they stay 0 until the first bitEn.
- R2: Each minor frame begins with the 32-bit sync pattern. The upper half is word slot 0 and the lower half is slot 1. Words are sent MSB first. Each bitEn sends one bit, and serOut takes the new bit on the clock edge that samples bitEn.
- R3: frameStart is high for exactly one clock, together with the first bit of slot 0. It is low at every other time.
- R4: Slot 2 carries the minor frame index, zero-extended to 16 bits. It counts 0, 1, ..., count-1 and then wraps to 0 at each major frame.
- R5: Slot 3 carries the value of timeIn sampled on the edge that sends the first sync bit of the same minor frame.
- R6: Slots 4 to len-1 are data slots. A data slot uses the map entry at address minor*(len-4)+(slot-4), taken modulo 256. In a map entry, bit 6 is 0 for a parameter and bits 5:0 give its index. A parameter slot carries that register's value as it stood at the word's first bit. Register writes made during the word's later bits do not change the word.
- R7: A map entry with bit 6 set is fill, and its slot carries 0x0000.
- R8: When one parameter is mapped to several slots of a minor frame, each slot carries the register value current at the start of that slot.
- R9: Map writes, cfgMinorLen (5..255 words), cfgMinorCount (1..255) and cfgSync take effect at the first bit after the last bit of a major frame. Until then, the running major frame keeps its old layout.
- R10: Without bitEn, serOut holds its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| bitEn | input | 1 | Bit-clock enable; each pulse sends one bit |
| paramWe | input | 1 | Parameter register write strobe |
| paramAddr | input | 6 | Parameter register index |
| paramData | input | 16 | Parameter write value |
| mapWe | input | 1 | Map table write strobe (staging copy) |
| mapAddr | input | 8 | Map table address |
| mapData | input | 7 | Map entry: bit 6 fill, bits 5:0 parameter index |
| cfgMinorLen | input | 8 | Words per minor frame, including the four header slots |
| cfgMinorCount | input | 8 | Minor frames per major frame |
| cfgSync | input | 32 | Sync pattern |
| timeIn | input | 16 | Time value captured at each minor frame start |
| serOut | output | 1 | Serial NRZ data |
| frameStart | output | 1 | One-clock strobe on the first sync bit |

## Verification
Every result is due one register stage after the bitEn edge. serOut and frameStart change on the same edge that samples bitEn, so the bench reads them at the next falling edge and collects 16 of these samples before it compares a whole word. The timestamp is checked 48 bits after the edge that captured it. Parameter writes happen only on idle clocks between bit pulses, so the model can fix each expected word at its first bit. Reconfiguration is checked by applying the new values to the reference model only after the last bit of the running major frame. An idle clock placed in the middle of each word checks that serOut holds and that frameStart has dropped.

// File: rtl/pcm_comm_pkg.sv
package pcm_comm_pkg;
  parameter int WORD_W    = 16;
  parameter int PARAM_N   = 64;
  parameter int MAP_DEPTH = 256;
  parameter int CFG_W     = 8;
  parameter int HDR_SLOTS = 4;

  localparam int SYNC_W  = 2 * WORD_W;
  localparam int PIDX_W  = $clog2(PARAM_N);
  localparam int ENTRY_W = PIDX_W + 1;
  localparam int MADDR_W = $clog2(MAP_DEPTH);
  localparam int BIT_W   = $clog2(WORD_W);

  typedef enum logic [2:0] {
    SLOT_SYNC_HI,
    SLOT_SYNC_LO,
    SLOT_COUNT,
    SLOT_STAMP,
    SLOT_DATA
  } slot_kind_e;

  typedef struct packed {
    logic                 bitStep;
    logic                 commit;
    slot_kind_e           kind;
    logic [BIT_W-1:0]     bitIdx;
    logic [CFG_W-1:0]     minorIdx;
    logic [MADDR_W-1:0]   mapAddr;
  } ctrl_strobe_t;
endpackage

// File: rtl/pcm_frame_ctrl.sv
module pcm_frame_ctrl
  import pcm_comm_pkg::*;
(
  input  logic               clk,
  input  logic               rst,
  input  logic               bitEn,
  input  logic [CFG_W-1:0]   cfgMinorLen,
  input  logic [CFG_W-1:0]   cfgMinorCount,
  output ctrl_strobe_t       ctrl
);
  localparam logic [BIT_W-1:0] LAST_BIT = BIT_W'(WORD_W - 1);

  logic [BIT_W-1:0]   bitIdx;
  logic [CFG_W-1:0]   slotIdx;
  logic [CFG_W-1:0]   minorIdx;
  logic [MADDR_W-1:0] mapPtr;
  logic [CFG_W-1:0]   lenAct;
  logic [CFG_W-1:0]   countAct;
  logic               started;
  slot_kind_e         kind;
  logic               lastBit, lastSlot, lastMinor, majorEnd;

  always_comb begin
    case (slotIdx)
      CFG_W'(0): kind = SLOT_SYNC_HI;
      CFG_W'(1): kind = SLOT_SYNC_LO;
      CFG_W'(2): kind = SLOT_COUNT;
      CFG_W'(3): kind = SLOT_STAMP;
      default:   kind = SLOT_DATA;
    endcase
  end

  assign lastBit   = (bitIdx == LAST_BIT);
  assign lastSlot  = (slotIdx == lenAct - CFG_W'(1));
  assign lastMinor = (minorIdx == countAct - CFG_W'(1));
  assign majorEnd  = bitEn && lastBit && lastSlot && lastMinor;

  always_ff @(posedge clk) begin
    if (rst) begin
      bitIdx   <= '0;
      slotIdx  <= '0;
      minorIdx <= '0;
      mapPtr   <= '0;
      lenAct   <= '0;
      countAct <= '0;
      started  <= 1'b0;
    end else begin
      if (!started) begin
        lenAct   <= cfgMinorLen;
        countAct <= cfgMinorCount;
      end
      if (bitEn) begin
        started <= 1'b1;
        if (lastBit) begin
          bitIdx <= '0;
          if (lastSlot) begin
            slotIdx <= '0;
            if (lastMinor) begin
              minorIdx <= '0;
              mapPtr   <= '0;
              lenAct   <= cfgMinorLen;
              countAct <= cfgMinorCount;
            end else begin
              minorIdx <= minorIdx + CFG_W'(1);
              if (kind == SLOT_DATA) mapPtr <= mapPtr + MADDR_W'(1);
            end
          end else begin
            slotIdx <= slotIdx + CFG_W'(1);
            if (kind == SLOT_DATA) mapPtr <= mapPtr + MADDR_W'(1);
          end
        end else begin
          bitIdx <= bitIdx + BIT_W'(1);
        end
      end
    end
  end

  always_comb begin
    ctrl.bitStep  = bitEn;
    ctrl.commit   = !started || majorEnd;
    ctrl.kind     = kind;
    ctrl.bitIdx   = bitIdx;
    ctrl.minorIdx = minorIdx;
    ctrl.mapAddr  = mapPtr;
  end

  // R1: counters sit at the frame origin until the first bit step
  a_r1_idle_origin: assert property (@(posedge clk) disable iff (rst)
    !started |-> (bitIdx == '0 && slotIdx == '0 && minorIdx == '0));

  // R4: minor frame index never reaches the working count
  a_r4_minor_range: assert property (@(posedge clk) disable iff (rst)
    (countAct != '0) |-> (minorIdx < countAct));

  // R2: slot index stays inside the working frame length
  a_r2_slot_range: assert property (@(posedge clk) disable iff (rst)
    (lenAct != '0) |-> (slotIdx < lenAct));

  // R9: once running, working layout changes only on a bit step
  a_r9_cfg_hold: assert property (@(posedge clk) disable iff (rst)
    (started && !bitEn) |=> ($stable(lenAct) && $stable(countAct)));
endmodule

// File: rtl/pcm_frame_dp.sv
module pcm_frame_dp
  import pcm_comm_pkg::*;
(
  input  logic               clk,
  input  logic               rst,
  input  ctrl_strobe_t       ctrl,
  input  logic               paramWe,
  input  logic [PIDX_W-1:0]  paramAddr,
  input  logic [WORD_W-1:0]  paramData,
  input  logic               mapWe,
  input  logic [MADDR_W-1:0] mapAddr,
  input  logic [ENTRY_W-1:0] mapData,
  input  logic [SYNC_W-1:0]  cfgSync,
  input  logic [WORD_W-1:0]  timeIn,
  output logic               serOut,
  output logic               frameStart
);
  localparam logic [ENTRY_W-1:0] FILL_ENTRY = {1'b1, {PIDX_W{1'b0}}};
  localparam logic [BIT_W-1:0]   TOP_BIT    = BIT_W'(WORD_W - 1);

  logic [WORD_W-1:0]  paramRegs [PARAM_N];
  logic [ENTRY_W-1:0] mapStage  [MAP_DEPTH];
  logic [ENTRY_W-1:0] mapAct    [MAP_DEPTH];
  logic [SYNC_W-1:0]  syncAct;
  logic [WORD_W-1:0]  stampReg;
  logic [WORD_W-1:0]  wordReg;
  logic [WORD_W-1:0]  nextWord;
  logic [ENTRY_W-1:0] curEntry;
  logic [BIT_W-1:0]   selIdx;
  logic               firstSync;

  assign curEntry  = mapAct[ctrl.mapAddr];
  assign selIdx    = TOP_BIT - ctrl.bitIdx;
  assign firstSync = ctrl.bitStep && (ctrl.kind == SLOT_SYNC_HI) && (ctrl.bitIdx == '0);

  always_comb begin
    case (ctrl.kind)
      SLOT_SYNC_HI: nextWord = syncAct[SYNC_W-1:WORD_W];
      SLOT_SYNC_LO: nextWord = syncAct[WORD_W-1:0];
      SLOT_COUNT:   nextWord = {{(WORD_W-CFG_W){1'b0}}, ctrl.minorIdx};
      SLOT_STAMP:   nextWord = stampReg;
      default:      nextWord = curEntry[ENTRY_W-1] ? '0 : paramRegs[curEntry[PIDX_W-1:0]];
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < PARAM_N; i++) paramRegs[i] <= '0;
    end else if (paramWe) begin
      paramRegs[paramAddr] <= paramData;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < MAP_DEPTH; i++) mapStage[i] <= FILL_ENTRY;
    end else if (mapWe) begin
      mapStage[mapAddr] <= mapData;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < MAP_DEPTH; i++) mapAct[i] <= FILL_ENTRY;
      syncAct <= '0;
    end else if (ctrl.commit) begin
      for (int i = 0; i < MAP_DEPTH; i++) mapAct[i] <= mapStage[i];
      syncAct <= cfgSync;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      stampReg   <= '0;
      wordReg    <= '0;
      serOut     <= 1'b0;
      frameStart <= 1'b0;
    end else begin
      frameStart <= firstSync;
      if (firstSync) stampReg <= timeIn;
      if (ctrl.bitStep) begin
        if (ctrl.bitIdx == '0) begin
          wordReg <= nextWord;
          serOut  <= nextWord[WORD_W-1];
        end else begin
          serOut  <= wordReg[selIdx];
        end
      end
    end
  end

  // R10: output bit holds between bit steps
  a_r10_hold: assert property (@(posedge clk) disable iff (rst)
    !ctrl.bitStep |=> $stable(serOut));

  // R3: frame strobe lasts a single clock
  a_r3_single_pulse: assert property (@(posedge clk) disable iff (rst)
    frameStart |=> !frameStart);

  // R3: frame strobe only follows a bit step
  a_r3_on_step: assert property (@(posedge clk) disable iff (rst)
    !ctrl.bitStep |=> !frameStart);
endmodule

// File: rtl/pcm_commutator.sv
module pcm_commutator
  import pcm_comm_pkg::*;
(
  input  logic               clk,
  input  logic               rst,
  input  logic               bitEn,
  input  logic               paramWe,
  input  logic [PIDX_W-1:0]  paramAddr,
  input  logic [WORD_W-1:0]  paramData,
  input  logic               mapWe,
  input  logic [MADDR_W-1:0] mapAddr,
  input  logic [ENTRY_W-1:0] mapData,
  input  logic [CFG_W-1:0]   cfgMinorLen,
  input  logic [CFG_W-1:0]   cfgMinorCount,
  input  logic [SYNC_W-1:0]  cfgSync,
  input  logic [WORD_W-1:0]  timeIn,
  output logic               serOut,
  output logic               frameStart
);
  ctrl_strobe_t ctrl;

  pcm_frame_ctrl u_ctrl (
    .clk           (clk),
    .rst           (rst),
    .bitEn         (bitEn),
    .cfgMinorLen   (cfgMinorLen),
    .cfgMinorCount (cfgMinorCount),
    .ctrl          (ctrl)
  );

  pcm_frame_dp u_dp (
    .clk        (clk),
    .rst        (rst),
    .ctrl       (ctrl),
    .paramWe    (paramWe),
    .paramAddr  (paramAddr),
    .paramData  (paramData),
    .mapWe      (mapWe),
    .mapAddr    (mapAddr),
    .mapData    (mapData),
    .cfgSync    (cfgSync),
    .timeIn     (timeIn),
    .serOut     (serOut),
    .frameStart (frameStart)
  );
endmodule

// File: tb/pcm_commutator_test.sv
module pcm_commutator_test;
  localparam int CLK_PERIOD = 10;
  localparam int SUPER_IDX  = 9;

  logic        clk = 1'b0;
  logic        rst;
  logic        bitEn;
  logic        paramWe;
  logic [5:0]  paramAddr;
  logic [15:0] paramData;
  logic        mapWe;
  logic [7:0]  mapAddr;
  logic [6:0]  mapData;
  logic [7:0]  cfgMinorLen;
  logic [7:0]  cfgMinorCount;
  logic [31:0] cfgSync;
  logic [15:0] timeIn;
  logic        serOut;
  logic        frameStart;

  always #(CLK_PERIOD/2) clk = ~clk;

  pcm_commutator uut (
    .clk(clk), .rst(rst), .bitEn(bitEn),
    .paramWe(paramWe), .paramAddr(paramAddr), .paramData(paramData),
    .mapWe(mapWe), .mapAddr(mapAddr), .mapData(mapData),
    .cfgMinorLen(cfgMinorLen), .cfgMinorCount(cfgMinorCount), .cfgSync(cfgSync),
    .timeIn(timeIn), .serOut(serOut), .frameStart(frameStart)
  );

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  logic [15:0] mParam [64];
  logic [6:0]  mStage [256];
  logic [6:0]  mAct   [256];
  int mLen, mCnt, cLen, cCnt;
  logic [31:0] mSync;
  int mBit = 0, mSlot = 0, mMinor = 0, majors = 0, reprog = 0;
  logic [15:0] expWord, gotWord, tsExp;
  string tag;

  task automatic check(bit ok, string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=0x%0h expected=0x%0h (minor %0d slot %0d)", req, act, exp, mMinor, mSlot);
    end
  endtask

  function automatic int modelAddr();
    return (mMinor * (mLen - 4) + (mSlot - 4)) % 256;
  endfunction

  function automatic logic [15:0] modelWord();
    logic [6:0] e;
    case (mSlot)
      0: return mSync[31:16];
      1: return mSync[15:0];
      2: return 16'(mMinor);
      3: return tsExp;
      default: begin
        e = mAct[modelAddr()];
        return e[6] ? 16'h0000 : mParam[e[5:0]];
      end
    endcase
  endfunction

  function automatic string modelTag();
    logic [6:0] e;
    if (mSlot < 2) return "R2";
    if (mSlot == 2) return "R4";
    if (mSlot == 3) return "R5";
    if (reprog > 0) return "R9";
    e = mAct[modelAddr()];
    if (e[6]) return "R7";
    if (e[5:0] == 6'(SUPER_IDX)) return "R8";
    return "R6";
  endfunction

  task automatic wrParam(int idx, logic [15:0] v);
    paramWe = 1'b1; paramAddr = 6'(idx); paramData = v;
    @(posedge clk); @(negedge clk);
    paramWe = 1'b0;
    mParam[idx] = v;
  endtask

  task automatic wrMap(int a, logic [6:0] v);
    mapWe = 1'b1; mapAddr = 8'(a); mapData = v;
    @(posedge clk); @(negedge clk);
    mapWe = 1'b0;
    mStage[a] = v;
  endtask

  function automatic logic [6:0] randEntry();
    if ($urandom_range(0, 4) == 0) return 7'h40;
    return {1'b0, 6'($urandom_range(0, 63))};
  endfunction

  // R6 / R8: writes land on idle clocks, often between bits of a word
  task automatic doBit();
    bit held;
    if ($urandom_range(0, 3) == 0)
      wrParam(($urandom_range(0, 1) == 0) ? SUPER_IDX : int'($urandom_range(0, 63)), 16'($urandom));
    timeIn = 16'($urandom);
    bitEn = 1'b1;
    if (mBit == 0) begin
      if (mSlot == 0) tsExp = timeIn;
      expWord = modelWord();
      tag = modelTag();
    end
    @(posedge clk); @(negedge clk);
    bitEn = 1'b0;
    gotWord[15 - mBit] = serOut;
    if (mBit == 0)
      check(frameStart == (mSlot == 0), "R3", 32'(frameStart), 32'(mSlot == 0));
    if (mBit == 7) begin
      held = serOut;
      @(posedge clk); @(negedge clk);
      check(serOut == held && frameStart == 1'b0, "R10", {30'd0, frameStart, serOut}, {31'd0, held});
    end
    if (mBit == 15) check(gotWord == expWord, tag, 32'(gotWord), 32'(expWord));
    mBit++;
    if (mBit == 16) begin
      mBit = 0; mSlot++;
      if (mSlot == mLen) begin
        mSlot = 0; mMinor++;
        if (mMinor == mCnt) begin
          mMinor = 0; majors++;
          mLen = cLen; mCnt = cCnt; mSync = cfgSync;
          mAct = mStage;
          if (reprog > 0) reprog--;
        end
      end
    end
  endtask

  task automatic runBits(int n);
    for (int i = 0; i < n; i++) doBit();
  endtask

  task automatic runToMajor(int target);
    while (majors < target) doBit();
  endtask

  // R9: new layout written mid-major; applies only after the boundary
  task automatic reprogram(int len, int cnt, logic [31:0] sync, int superStep);
    int dSlots = len - 4;
    for (int m = 0; m < cnt; m++)
      for (int d = 0; d < dSlots; d++)
        wrMap(m * dSlots + d, (superStep > 0 && d % superStep == 0) ? 7'(SUPER_IDX) : randEntry());
    cfgMinorLen = 8'(len); cfgMinorCount = 8'(cnt); cfgSync = sync;
    cLen = len; cCnt = cnt;
    reprog = 2;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      failures++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd20240611));
    rst = 1'b1; bitEn = 1'b0; paramWe = 1'b0; paramAddr = '0; paramData = '0;
    mapWe = 1'b0; mapAddr = '0; mapData = '0; timeIn = '0;
    cfgMinorLen = 8'd12; cfgMinorCount = 8'd4; cfgSync = 32'hFE6B_2840;
    for (int i = 0; i < 64; i++) mParam[i] = '0;
    for (int i = 0; i < 256; i++) mStage[i] = 7'h40;
    repeat (5) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1: quiet after reset and with no bit enable
    check(serOut == 1'b0, "R1", 32'(serOut), 32'd0);
    check(frameStart == 1'b0, "R1", 32'(frameStart), 32'd0);
    for (int i = 0; i < 64; i++) wrParam(i, 16'($urandom));
    // Layout A: 8 data slots, parameter 9 at quarter points
    cLen = 12; cCnt = 4;
    for (int m = 0; m < 4; m++)
      for (int d = 0; d < 8; d++)
        wrMap(m * 8 + d, (d % 2 == 0) ? 7'(SUPER_IDX) : randEntry());
    check(serOut == 1'b0 && frameStart == 1'b0, "R1", {30'd0, frameStart, serOut}, 32'd0);
    mLen = cLen; mCnt = cCnt; mSync = cfgSync; mAct = mStage;
    runToMajor(1);
    runBits(12 * 16 + 40);
    reprogram(10, 3, 32'h1ACF_FC1D, 3);
    runToMajor(4);
    runBits(7 * 16 + 5);
    // Single minor frame per major: counter must stay 0
    reprogram(6, 1, 32'hA5A5_0F0F, 0);
    wrMap(0, 7'(SUPER_IDX));
    wrMap(1, 7'h40);
    runToMajor(9);
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule